// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences one processor core through its idle states. From the running state, a halt request puts the core into one of two clock-stopped states. The deeper state, which also asks for a lower core ratio and voltage, is chosen only when software has enabled it and the core is not already at its lowest bus-to-core ratio. Otherwise the shallow halt state is chosen. A wake event brings the core back to running. Leaving the deep state first withdraws the ratio request and then waits a fixed number of settle cycles before the core clock returns.

An active-low stop-clock input has priority over every other input. It is wired in parallel to every core controller in the system, so all of them enter the stop-grant state on the same edge. On entry, each controller emits a single-cycle pulse that launches its stop-grant acknowledge bus cycle. When the input is released, the controller goes back to the state it held before the stop.

All inputs are assumed to be synchronous to `clk_i`. The state is visible on `state_o`. Clock-gate and ratio outputs are decoded directly from the registered state, so they change in the first cycle after the edge that changes the state.

Top module: `lps_ctrl`

## Requirements
- R1: During and after reset, `state_o` is 0 (running), `core_clk_en_o` is 1, and both `ratio_low_o` and `sbc_pulse_o` are 0.
- R2: When the state is running, `stopclk_ni` is high and `halt_req_i` is high, with `deep_en_i`=1 and `min_ratio_i`=0, the next state is 2 (deep halt).
- R3: When the state is running, `stopclk_ni` is high and `halt_req_i` is high, with `deep_en_i`=0 or `min_ratio_i`=1, the next state is 1 (halt).
- R4: When the state is halt (1), `stopclk_ni` is high and `wake_i` is high, the next state is running (0).
- R5: When the state is deep halt (2), `stopclk_ni` is high and `wake_i` is high, the next state is 3 (wake settle) with `ratio_low_o` at 0. The state stays 3 for exactly `SETTLE_CYC` cycles and then becomes running.
- R6: `stopclk_ni` low in any state makes the next state 4 (stop-grant). This takes priority over `halt_req_i` and `wake_i`.
- R7: `sbc_pulse_o` is high for exactly one cycle, which is the first cycle in state 4. It does not repeat while `stopclk_ni` stays low. It fires again after a release followed by a new assertion.
- R8: When `stopclk_ni` is high in state 4, the next state is the state held before entry (0, 1 or 2). A stop taken from state 3 returns to 0.
- R9: `halt_req_i` has no effect outside the running state. `wake_i` has no effect in the running and stop-grant states. A halt interrupted by stop-grant still needs a wake after release.
- R10: `core_clk_en_o` is 1 only in state 0. `ratio_low_o` is 1 only in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| halt_req_i | input | 1 | Halt instruction request |
| stopclk_ni | input | 1 | Active-low stop-clock request, shared by all cores |
| deep_en_i | input | 1 | Software enable for deep halt |
| min_ratio_i | input | 1 | Core already at lowest bus-to-core ratio |
| wake_i | input | 1 | Wake or interrupt event |
| core_clk_en_o | output | 1 | Core clock-gate enable |
| ratio_low_o | output | 1 | Request for lower ratio and voltage |
| sbc_pulse_o | output | 1 | One-cycle stop-grant bus-cycle launch |
| state_o | output | 3 | Current state: 0 run, 1 halt, 2 deep halt, 3 wake settle, 4 stop-grant |

## Verification
A wrong state or a wrong saved return state shows on `state_o` and on the gate outputs in the cycle after the faulty edge. It is detected by the next check. A settle counter that is off by one moves the return of `core_clk_en_o` by one cycle, which the cycle-counted settle check exposes. A missing or repeated acknowledge appears on `sbc_pulse_o` during the cycles held in stop-grant. The bench sweeps every combination of the enable and ratio flags, and every state from which stop-grant can be entered.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_HALT  = 3'd1,
        ST_XHALT = 3'd2,
        ST_WAKE  = 3'd3,
        ST_STPG  = 3'd4
    } lps_state_e;

    typedef struct packed {
        lps_state_e cur;
        lps_state_e ret;
    } lps_regs_t;

endpackage

// File: rtl/lps_target_sel.sv
module lps_target_sel
    import lps_pkg::*;
(
    input  logic       deep_en_i,
    input  logic       min_ratio_i,
    output lps_state_e target_o
);

    // Deep halt only when software allows it and a lower ratio is still possible.
    always_comb begin
        if (deep_en_i && !min_ratio_i) begin
            target_o = ST_XHALT;
        end else begin
            target_o = ST_HALT;
        end
    end

endmodule

// File: rtl/lps_settle_timer.sv
module lps_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic done_o
);

    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lps_sbc_gen.sv
module lps_sbc_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enter_i,
    output logic pulse_o
);

    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = enter_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       halt_req_i,
    input  logic       stopclk_ni,
    input  logic       deep_en_i,
    input  logic       min_ratio_i,
    input  logic       wake_i,
    output logic       core_clk_en_o,
    output logic       ratio_low_o,
    output logic       sbc_pulse_o,
    output logic [2:0] state_o
);

    lps_regs_t  st_d, st_q;
    lps_state_e halt_target;
    logic       settle_load;
    logic       settle_done;
    logic       enter_stpg;

    lps_target_sel u_target (
        .deep_en_i   (deep_en_i),
        .min_ratio_i (min_ratio_i),
        .target_o    (halt_target)
    );

    lps_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (settle_load),
        .done_o (settle_done)
    );

    always_comb begin
        st_d        = st_q;
        settle_load = 1'b0;
        if (!stopclk_ni) begin
            // The stop request overrides everything; save where to come back to.
            if (st_q.cur != ST_STPG) begin
                st_d.cur = ST_STPG;
                st_d.ret = (st_q.cur == ST_WAKE) ? ST_RUN : st_q.cur;
            end
        end else begin
            unique case (st_q.cur)
                ST_RUN: begin
                    if (halt_req_i) begin
                        st_d.cur = halt_target;
                    end
                end
                ST_HALT: begin
                    if (wake_i) begin
                        st_d.cur = ST_RUN;
                    end
                end
                ST_XHALT: begin
                    if (wake_i) begin
                        st_d.cur    = ST_WAKE;
                        settle_load = 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (settle_done) begin
                        st_d.cur = ST_RUN;
                    end
                end
                ST_STPG: begin
                    st_d.cur = st_q.ret;
                end
                default: begin
                    st_d.cur = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cur <= ST_RUN;
            st_q.ret <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign enter_stpg = (st_d.cur == ST_STPG) && (st_q.cur != ST_STPG);

    lps_sbc_gen u_sbc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .enter_i (enter_stpg),
        .pulse_o (sbc_pulse_o)
    );

    assign core_clk_en_o = (st_q.cur == ST_RUN);
    assign ratio_low_o   = (st_q.cur == ST_XHALT);
    assign state_o       = st_q.cur;

endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk
    import lps_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       halt_req_i,
    input logic       stopclk_ni,
    input logic       deep_en_i,
    input logic       min_ratio_i,
    input logic       wake_i,
    input logic       ratio_low_o,
    input logic       sbc_pulse_o,
    input logic [2:0] state_o
);

    a_r2_deep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RUN && stopclk_ni && halt_req_i && deep_en_i && !min_ratio_i)
        |=> (state_o == ST_XHALT));

    a_r3_plain_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RUN && stopclk_ni && halt_req_i && (!deep_en_i || min_ratio_i))
        |=> (state_o == ST_HALT));

    a_r4_halt_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_HALT && stopclk_ni && wake_i) |=> (state_o == ST_RUN));

    a_r5_deep_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_XHALT && stopclk_ni && wake_i)
        |=> (state_o == ST_WAKE && !ratio_low_o));

    a_r6_stop_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stopclk_ni |=> (state_o == ST_STPG));

    a_r7_sbc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sbc_pulse_o |=> !sbc_pulse_o);

    a_r7_sbc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sbc_pulse_o |-> (state_o == ST_STPG && $past(state_o) != ST_STPG));

    a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_STPG && stopclk_ni) |=> (state_o != ST_STPG && !sbc_pulse_o));

    a_r9_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_HALT && stopclk_ni && !wake_i) |=> (state_o == ST_HALT));

endmodule

bind lps_ctrl lps_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_req_i  (halt_req_i),
    .stopclk_ni  (stopclk_ni),
    .deep_en_i   (deep_en_i),
    .min_ratio_i (min_ratio_i),
    .wake_i      (wake_i),
    .ratio_low_o (ratio_low_o),
    .sbc_pulse_o (sbc_pulse_o),
    .state_o     (state_o)
);

// File: tb/lps_ctrl_tb.sv
module lps_ctrl_tb;

    localparam int SETTLE = 4;

    logic       clk       = 1'b0;
    logic       rst_n     = 1'b0;
    logic       halt_req  = 1'b0;
    logic       stopclk_n = 1'b1;
    logic       deep_en   = 1'b0;
    logic       min_ratio = 1'b0;
    logic       wake      = 1'b0;
    logic       core_clk_en;
    logic       ratio_low;
    logic       sbc;
    logic [2:0] state;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lps_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .halt_req_i    (halt_req),
        .stopclk_ni    (stopclk_n),
        .deep_en_i     (deep_en),
        .min_ratio_i   (min_ratio),
        .wake_i        (wake),
        .core_clk_en_o (core_clk_en),
        .ratio_low_o   (ratio_low),
        .sbc_pulse_o   (sbc),
        .state_o       (state)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R10: the clock gate is on only in state 0; the ratio request only in state 2.
    task automatic expect_state(input string rq, input int st);
        chk(rq, int'(state), st);
        chk({rq, " R10 clk_en"}, int'(core_clk_en), (st == 0) ? 1 : 0);
        chk({rq, " R10 ratio_low"}, int'(ratio_low), (st == 2) ? 1 : 0);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        halt_req  = 1'b0;
        wake      = 1'b0;
        stopclk_n = 1'b1;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // Bring the controller to state p (0..3) from reset.
    task automatic go_to(input int p);
        do_reset();
        if (p != 0) begin
            deep_en   = (p >= 2);
            min_ratio = 1'b0;
            halt_req  = 1'b1;
            step();
            halt_req = 1'b0;
            if (p == 3) begin
                wake = 1'b1;
                step();
                wake = 1'b0;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        // R1: reset values
        expect_state("R1 reset state", 0);
        chk("R1 reset sbc", int'(sbc), 0);
        do_reset();
        expect_state("R1 after reset", 0);

        // R9: a wake while running is ignored
        wake = 1'b1;
        step();
        wake = 1'b0;
        expect_state("R9 wake in run", 0);

        // R2/R3: sweep the enable and ratio flags
        for (int de = 0; de < 2; de++) begin
            for (int mr = 0; mr < 2; mr++) begin
                int exp_st;
                do_reset();
                deep_en   = de[0];
                min_ratio = mr[0];
                exp_st    = (de == 1 && mr == 0) ? 2 : 1;
                halt_req  = 1'b1;
                step();
                expect_state((exp_st == 2) ? "R2 deep entry" : "R3 plain entry", exp_st);
                // R9: a repeated halt request is ignored outside run
                step();
                halt_req = 1'b0;
                expect_state("R9 halt ignored", exp_st);
                wake = 1'b1;
                step();
                wake = 1'b0;
                if (exp_st == 1) begin
                    expect_state("R4 wake from halt", 0);
                end else begin
                    int n;
                    expect_state("R5 wake settle", 3);
                    n = 0;
                    while (state == 3'd3 && n < 50) begin
                        n++;
                        step();
                    end
                    chk("R5 settle cycles", n, SETTLE);
                    expect_state("R5 back to run", 0);
                end
            end
        end

        // R6/R7/R8: stop-grant from each prior state
        for (int p = 0; p < 4; p++) begin
            go_to(p);
            halt_req  = 1'b1;
            wake      = 1'b1;
            stopclk_n = 1'b0;
            step();
            halt_req = 1'b0;
            expect_state("R6 stop entry", 4);
            chk("R7 sbc pulse", int'(sbc), 1);
            for (int k = 0; k < 3; k++) begin
                step();
                chk("R7 no repeat sbc", int'(sbc), 0);
                chk("R9 wake ignored in stop", int'(state), 4);
            end
            wake      = 1'b0;
            stopclk_n = 1'b1;
            step();
            expect_state("R8 return state", (p == 3) ? 0 : p);
            chk("R8 sbc low", int'(sbc), 0);
            if (p == 1) begin
                step();
                expect_state("R9 halt persists", 1);
            end
            stopclk_n = 1'b0;
            step();
            chk("R7 sbc after reassert", int'(sbc), 1);
            stopclk_n = 1'b1;
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule